// File: doc/BRIEF.md
# Binary32 / Binary64 Floating-Point Format Converter

This block converts one IEEE-754 value per cycle between single precision (binary32) and double precision (binary64). A direction input selects widening (binary32 held in the low 32 bits of the operand, producing a binary64 pattern) or narrowing (binary64 operand, producing a binary32 pattern in the low 32 bits of the result). A 2-bit rounding-mode input controls narrowing, and a denormals-are-zero control makes subnormal inputs count as signed zero.

Along with the bit pattern, the block reports five exception flags: invalid, denormal operand, overflow, underflow and inexact. All exceptions are treated as masked. NaNs keep their sign and payload. Signaling NaNs come out quiet. An overflow on narrowing saturates to infinity or to the largest finite value, depending on the mode and the sign. Underflowed results are rounded into the subnormal range. The conversion logic is combinational and feeds a single output register, which loads when the input is marked valid.

Top module: `fpc_convert`

## Requirements
- R1: A result and its flags appear on the outputs at the first rising clock edge after `in_valid` is sampled high, and `out_valid` is high for that cycle. While `in_valid` is low, the result and flags hold their previous values and `out_valid` is low.
- R2: Widening normals, zeros and infinities is exact. The sign is kept, the exponent is rebiased by +896, 29 zero bits are appended to the fraction, and no flag is raised.
- R3: Widening a binary32 subnormal with `daz`=0 normalises it into an exact binary64 normal and raises only the denormal flag. With `daz`=1 it gives a zero of the same sign and no flag.
- R4: Widening a NaN gives sign unchanged, exponent all ones, and the 23-bit fraction followed by 29 zeros, with result bit 51 forced to 1. The invalid flag is raised only when input bit 22 was 0 (signaling); a quiet NaN raises no flag.
- R5: Narrowing a NaN gives sign unchanged, exponent 0xFF, and input fraction bits 51..29 as the result fraction, with result bit 22 forced to 1. Invalid is raised only when input bit 51 was 0.
- R6: Narrowing rounds with `rmode` encoded 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. The decision uses the guard bit, the round bit and the OR of the remaining dropped bits. Any nonzero dropped bit raises inexact.
- R7: When the rounded narrowed magnitude exceeds the largest binary32 finite value, overflow and inexact are set. The result is infinity for nearest-even. Toward plus infinity gives +infinity for positive inputs and the largest negative finite value for negative inputs. Toward minus infinity gives the largest positive finite value for positive inputs and -infinity for negative inputs. Toward zero gives the largest finite value of the input's sign.
- R8: A narrowed value is tiny when, rounded to 24 bits with an unbounded exponent, it stays below 2^-126. A tiny value is rounded into the subnormal encoding. Underflow and inexact are raised only when that rounding loses bits; an exact tiny result raises no flag.
- R9: Narrowing a binary64 subnormal with `daz`=0 raises the denormal flag, plus underflow and inexact. The result is zero, or the smallest subnormal when the mode rounds away from zero. With `daz`=1 the result is a zero of the same sign with no flags.
- R10: A narrowed result occupies bits 31..0 and bits 63..32 are zero. Infinities and zeros narrow with their sign and no flag.
- R11: A rounding carry out of the fraction increments the exponent. This includes an all-ones significand rounding up to the next power of two, and a subnormal rounding up to the smallest normal.
- R12: While `rst_n` is low, and after its release until the first valid input, `out_valid`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid; loads the output register |
| narrow | input | 1 | 1 = binary64 to binary32, 0 = binary32 to binary64 |
| opnd | input | 64 | Operand (binary32 in bits 31..0 when widening) |
| rmode | input | 2 | Rounding mode for narrowing |
| daz | input | 1 | Treat subnormal inputs as signed zero |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Converted bit pattern |
| exc_invalid | output | 1 | Signaling NaN input |
| exc_denorm | output | 1 | Subnormal input seen with `daz` off |
| exc_overflow | output | 1 | Narrowed result overflowed |
| exc_underflow | output | 1 | Tiny and inexact narrowed result |
| exc_inexact | output | 1 | Result differs from the exact value |

## Verification
Each result, its five flags and `out_valid` are due exactly one rising edge after the operand is presented with `in_valid` high. Only `out_valid` falls back low one edge after `in_valid` drops; the result and flags keep their values. The bench therefore changes inputs on the falling edge, holds `in_valid` for one cycle, and compares every output on the next falling edge, half a cycle after the register has loaded. The hold and reset checks look at the outputs on falling edges after the operand has been changed with `in_valid` low, and during and after an asynchronous reset pulse.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int SP_EW     = 8;
  localparam int SP_FW     = 23;
  localparam int DP_EW     = 11;
  localparam int DP_FW     = 52;
  localparam int SP_W      = 1 + SP_EW + SP_FW;
  localparam int DP_W      = 1 + DP_EW + DP_FW;
  localparam int SP_BIAS   = (1 << (SP_EW - 1)) - 1;
  localparam int DP_BIAS   = (1 << (DP_EW - 1)) - 1;
  localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
  localparam int DROP_W    = DP_FW - SP_FW;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic denorm;
    logic overflow;
    logic underflow;
    logic inexact;
  } exc_t;

  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
    logic is_snan;
  } cls_t;

  // increment decision for magnitude rounding
  function automatic logic round_inc(rmode_e m, logic sgn, logic lsb,
                                     logic g, logic r, logic st);
    logic lost;
    lost = g | r | st;
    case (m)
      RM_NEAR: return g & (r | st | lsb);
      RM_DOWN: return sgn & lost;
      RM_UP:   return ~sgn & lost;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW-1:0] val,
  output fpc_pkg::cls_t    cls
);
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;

  assign ex = val[EW+FW-1:FW];
  assign fr = val[FW-1:0];

  always_comb begin
    cls.is_zero = (ex == '0) && (fr == '0);
    cls.is_sub  = (ex == '0) && (fr != '0);
    cls.is_inf  = (&ex) && (fr == '0);
    cls.is_nan  = (&ex) && (fr != '0);
    cls.is_snan = (&ex) && (fr != '0) && !fr[FW-1];
  end
endmodule

// File: rtl/fpc_widen.sv
module fpc_widen
  import fpc_pkg::*;
(
  input  logic [SP_W-1:0] src,
  input  logic            daz,
  output logic [DP_W-1:0] res,
  output exc_t            exc
);
  localparam int PW = $clog2(SP_FW);

  logic             sgn;
  logic [SP_EW-1:0] ex;
  logic [SP_FW-1:0] fr;
  cls_t             cls;
  logic [PW-1:0]    lead;
  logic [SP_FW-1:0] nfrac;
  logic [DP_EW-1:0] nexp;
  logic [DP_EW-1:0] wexp;

  assign sgn = src[SP_W-1];
  assign ex  = src[SP_W-2:SP_FW];
  assign fr  = src[SP_FW-1:0];

  fpc_classify #(.EW(SP_EW), .FW(SP_FW)) u_cls (
    .val (src[SP_W-2:0]),
    .cls (cls)
  );

  function automatic logic [PW-1:0] top_one(logic [SP_FW-1:0] v);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < SP_FW; i++) begin
      if (v[i]) p = PW'(i);
    end
    return p;
  endfunction

  always_comb begin
    lead  = top_one(fr);
    nfrac = fr << (SP_FW - int'(lead));
    nexp  = DP_EW'(lead) + DP_EW'(BIAS_DIFF - SP_FW + 1);
    wexp  = DP_EW'(ex) + DP_EW'(BIAS_DIFF);
  end

  always_comb begin
    exc = '0;
    res = {sgn, {(DP_W-1){1'b0}}};
    if (cls.is_nan) begin
      res         = {sgn, {DP_EW{1'b1}}, 1'b1, fr[SP_FW-2:0], {DROP_W{1'b0}}};
      exc.invalid = cls.is_snan;
    end else if (cls.is_inf) begin
      res = {sgn, {DP_EW{1'b1}}, {DP_FW{1'b0}}};
    end else if (cls.is_sub) begin
      exc.denorm = !daz;
      if (!daz) res = {sgn, nexp, nfrac, {DROP_W{1'b0}}};
    end else if (!cls.is_zero) begin
      res = {sgn, wexp, fr, {DROP_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fpc_narrow.sv
module fpc_narrow
  import fpc_pkg::*;
(
  input  logic [DP_W-1:0] src,
  input  rmode_e          rmode,
  input  logic            daz,
  output logic [SP_W-1:0] res,
  output exc_t            exc
);
  localparam int KW  = SP_FW + 1;
  localparam int VW  = DP_FW + 1 + KW + 3;
  localparam int TW  = DP_EW + 2;
  localparam int SHW = 7;
  localparam logic [SP_EW-1:0] EXP_ONES = '1;

  logic             sgn;
  logic [DP_EW-1:0] ex;
  logic [DP_FW-1:0] fr;
  cls_t             cls;
  logic [DP_EW-1:0] ex_eff;
  logic [DP_FW:0]   sig;
  logic signed [TW-1:0] te;
  logic signed [TW-1:0] shraw;
  logic [SHW-1:0]   sh;
  logic [VW-1:0]    v;
  logic [VW-1:0]    vs;
  logic [KW-1:0]    kept;
  logic [KW-1:0]    ukept;
  logic             g, r, st, ug, ur, ust;
  logic             inc, uinc, ucarry, tiny, lossy;
  logic [KW:0]      rnd;
  logic [TW-1:0]    e_out;
  logic [SP_W-1:0]  inf_pat;
  logic [SP_W-1:0]  max_pat;
  logic [SP_W-1:0]  ovf_pat;

  assign sgn = src[DP_W-1];
  assign ex  = src[DP_W-2:DP_FW];
  assign fr  = src[DP_FW-1:0];

  fpc_classify #(.EW(DP_EW), .FW(DP_FW)) u_cls (
    .val (src[DP_W-2:0]),
    .cls (cls)
  );

  // alignment: exponent shift, sticky collection, two roundings
  always_comb begin
    ex_eff = (ex == '0) ? DP_EW'(1) : ex;
    sig    = {(ex != '0), fr};
    te     = $signed({2'b00, ex_eff}) - $signed(TW'(BIAS_DIFF));
    shraw  = $signed(TW'(1)) - te;
    if (te > 0)
      sh = '0;
    else if (shraw > $signed(TW'((1 << SHW) - 1)))
      sh = '1;
    else
      sh = shraw[SHW-1:0];

    v     = {sig, {(VW-DP_FW-1){1'b0}}};
    vs    = v >> sh;
    kept  = vs[VW-1 -: KW];
    g     = vs[VW-KW-1];
    r     = vs[VW-KW-2];
    st    = (|vs[VW-KW-3:0]) | (|(v & ~({VW{1'b1}} << sh)));
    lossy = g | r | st;
    inc   = round_inc(rmode, sgn, kept[0], g, r, st);
    rnd   = {1'b0, kept} + (KW+1)'(inc);

    ukept  = v[VW-1 -: KW];
    ug     = v[VW-KW-1];
    ur     = v[VW-KW-2];
    ust    = |v[VW-KW-3:0];
    uinc   = round_inc(rmode, sgn, ukept[0], ug, ur, ust);
    ucarry = (&ukept) & uinc;
    tiny   = !((te == '0) && ucarry);

    e_out  = te + TW'(rnd[KW]);
  end

  // saturated pattern on overflow
  always_comb begin
    inf_pat = {sgn, EXP_ONES, {SP_FW{1'b0}}};
    max_pat = {sgn, EXP_ONES - SP_EW'(1), {SP_FW{1'b1}}};
    case (rmode)
      RM_NEAR: ovf_pat = inf_pat;
      RM_DOWN: ovf_pat = sgn ? inf_pat : max_pat;
      RM_UP:   ovf_pat = sgn ? max_pat : inf_pat;
      default: ovf_pat = max_pat;
    endcase
  end

  always_comb begin
    exc = '0;
    res = {sgn, {(SP_W-1){1'b0}}};
    if (cls.is_nan) begin
      res         = {sgn, EXP_ONES, 1'b1, fr[DP_FW-2 -: SP_FW-1]};
      exc.invalid = cls.is_snan;
    end else if (cls.is_inf) begin
      res = inf_pat;
    end else if (cls.is_zero || (cls.is_sub && daz)) begin
      res = {sgn, {(SP_W-1){1'b0}}};
    end else begin
      exc.denorm  = cls.is_sub;
      exc.inexact = lossy;
      if (te > 0) begin
        if (e_out >= TW'(EXP_ONES)) begin
          res          = ovf_pat;
          exc.overflow = 1'b1;
          exc.inexact  = 1'b1;
        end else begin
          res = {sgn, e_out[SP_EW-1:0], rnd[SP_FW-1:0]};
        end
      end else begin
        res           = {sgn, {(SP_EW-1){1'b0}}, rnd[KW-1:0]};
        exc.underflow = tiny & lossy;
      end
    end
  end
endmodule

// File: rtl/fpc_convert.sv
module fpc_convert
  import fpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        narrow,
  input  logic [63:0] opnd,
  input  logic [1:0]  rmode,
  input  logic        daz,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        exc_invalid,
  output logic        exc_denorm,
  output logic        exc_overflow,
  output logic        exc_underflow,
  output logic        exc_inexact
);
  logic [DP_W-1:0] w_res;
  exc_t            w_exc;
  logic [SP_W-1:0] n_res;
  exc_t            n_exc;
  logic [DP_W-1:0] res_d, res_q;
  exc_t            exc_d, exc_q;
  logic            vld_q;

  fpc_widen u_widen (
    .src (opnd[SP_W-1:0]),
    .daz (daz),
    .res (w_res),
    .exc (w_exc)
  );

  fpc_narrow u_narrow (
    .src   (opnd),
    .rmode (rmode_e'(rmode)),
    .daz   (daz),
    .res   (n_res),
    .exc   (n_exc)
  );

  always_comb begin
    if (narrow) begin
      res_d = {{(DP_W-SP_W){1'b0}}, n_res};
      exc_d = n_exc;
    end else begin
      res_d = w_res;
      exc_d = w_exc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      exc_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        exc_q <= exc_d;
      end
    end
  end

  assign out_valid     = vld_q;
  assign result        = res_q;
  assign exc_invalid   = exc_q.invalid;
  assign exc_denorm    = exc_q.denorm;
  assign exc_overflow  = exc_q.overflow;
  assign exc_underflow = exc_q.underflow;
  assign exc_inexact   = exc_q.inexact;
endmodule

// File: rtl/fpc_convert_chk.sv
module fpc_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        narrow,
  input logic [63:0] opnd,
  input logic        daz,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        exc_invalid,
  input logic        exc_denorm,
  input logic        exc_overflow,
  input logic        exc_underflow,
  input logic        exc_inexact
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(result) && !out_valid)); // R1
  AST_WIDEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !narrow) |=> (!exc_overflow && !exc_underflow && !exc_inexact)); // R2
  AST_DAZ_NO_DENORM: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && daz) |=> !exc_denorm); // R3
  AST_WIDEN_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !narrow && (opnd[30:23] == 8'hFF) && (opnd[22:0] != '0)) |=> (result[62:51] == 12'hFFF)); // R4
  AST_NARROW_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && narrow && (opnd[62:52] == 11'h7FF) && (opnd[51:0] != '0)) |=> (result[30:22] == 9'h1FF)); // R5
  AST_QNAN_NO_INVALID: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && narrow && (opnd[62:51] == 12'hFFF)) |=> !exc_invalid); // R5
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && exc_overflow) |-> exc_inexact); // R7
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && exc_underflow) |-> exc_inexact); // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && narrow) |=> (result[63:32] == '0)); // R10
endmodule

bind fpc_convert fpc_convert_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .narrow        (narrow),
  .opnd          (opnd),
  .daz           (daz),
  .out_valid     (out_valid),
  .result        (result),
  .exc_invalid   (exc_invalid),
  .exc_denorm    (exc_denorm),
  .exc_overflow  (exc_overflow),
  .exc_underflow (exc_underflow),
  .exc_inexact   (exc_inexact)
);

// File: tb/fpc_convert_bench.sv
`timescale 1ns/1ps
module fpc_convert_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        narrow;
  logic [63:0] opnd;
  logic [1:0]  rmode;
  logic        daz;
  logic        out_valid;
  logic [63:0] result;
  logic        exc_invalid, exc_denorm, exc_overflow, exc_underflow, exc_inexact;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  fpc_convert u_fpc_convert (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .narrow        (narrow),
    .opnd          (opnd),
    .rmode         (rmode),
    .daz           (daz),
    .out_valid     (out_valid),
    .result        (result),
    .exc_invalid   (exc_invalid),
    .exc_denorm    (exc_denorm),
    .exc_overflow  (exc_overflow),
    .exc_underflow (exc_underflow),
    .exc_inexact   (exc_inexact)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // entry: narrow, rmode, daz, operand, expected result, flags {I,D,O,U,P}, requirement number
  localparam int NV = 46;
  localparam logic [144:0] VEC [NV] = '{
    {1'b0,2'd0,1'b0,64'h3F800000,64'h3FF0000000000000,5'b00000,8'd2},  // R2
    {1'b0,2'd0,1'b0,64'hFF800000,64'hFFF0000000000000,5'b00000,8'd2},  // R2
    {1'b0,2'd0,1'b0,64'h80000000,64'h8000000000000000,5'b00000,8'd2},  // R2
    {1'b0,2'd0,1'b0,64'h40490FDB,64'h400921FB60000000,5'b00000,8'd2},  // R2
    {1'b0,2'd3,1'b0,64'h7F7FFFFF,64'h47EFFFFFE0000000,5'b00000,8'd2},  // R2
    {1'b0,2'd0,1'b0,64'h00000001,64'h36A0000000000000,5'b01000,8'd3},  // R3
    {1'b0,2'd0,1'b0,64'h80400000,64'hB800000000000000,5'b01000,8'd3},  // R3
    {1'b0,2'd0,1'b1,64'h00000001,64'h0000000000000000,5'b00000,8'd3},  // R3
    {1'b0,2'd0,1'b1,64'h80400000,64'h8000000000000000,5'b00000,8'd3},  // R3
    {1'b0,2'd0,1'b0,64'h7FC00001,64'h7FF8000020000000,5'b00000,8'd4},  // R4
    {1'b0,2'd0,1'b0,64'hFF800001,64'hFFF8000020000000,5'b10000,8'd4},  // R4
    {1'b1,2'd0,1'b0,64'h7FF8000000000001,64'h7FC00000,5'b00000,8'd5},  // R5
    {1'b1,2'd0,1'b0,64'hFFF0000020000000,64'hFFC00001,5'b10000,8'd5},  // R5
    {1'b1,2'd0,1'b0,64'h3FF0000000000000,64'h3F800000,5'b00000,8'd6},  // R6
    {1'b1,2'd0,1'b0,64'h3FF0000010000000,64'h3F800000,5'b00001,8'd6},  // R6
    {1'b1,2'd2,1'b0,64'h3FF0000010000000,64'h3F800001,5'b00001,8'd6},  // R6
    {1'b1,2'd0,1'b0,64'h3FF0000018000000,64'h3F800001,5'b00001,8'd6},  // R6
    {1'b1,2'd1,1'b0,64'hBFF0000010000001,64'hBF800001,5'b00001,8'd6},  // R6
    {1'b1,2'd3,1'b0,64'hBFF0000010000001,64'hBF800000,5'b00001,8'd6},  // R6
    {1'b1,2'd2,1'b0,64'hBFF0000010000001,64'hBF800000,5'b00001,8'd6},  // R6
    {1'b1,2'd0,1'b0,64'h3FF0000030000000,64'h3F800002,5'b00001,8'd6},  // R6
    {1'b1,2'd0,1'b0,64'h47EFFFFFE0000000,64'h7F7FFFFF,5'b00000,8'd6},  // R6
    {1'b1,2'd0,1'b0,64'h3FFFFFFFF0000000,64'h40000000,5'b00001,8'd11}, // R11
    {1'b1,2'd0,1'b0,64'h47F0000000000000,64'h7F800000,5'b00101,8'd7},  // R7
    {1'b1,2'd2,1'b0,64'h47F0000000000000,64'h7F800000,5'b00101,8'd7},  // R7
    {1'b1,2'd1,1'b0,64'h47F0000000000000,64'h7F7FFFFF,5'b00101,8'd7},  // R7
    {1'b1,2'd3,1'b0,64'h47F0000000000000,64'h7F7FFFFF,5'b00101,8'd7},  // R7
    {1'b1,2'd0,1'b0,64'hC7F0000000000000,64'hFF800000,5'b00101,8'd7},  // R7
    {1'b1,2'd1,1'b0,64'hC7F0000000000000,64'hFF800000,5'b00101,8'd7},  // R7
    {1'b1,2'd2,1'b0,64'hC7F0000000000000,64'hFF7FFFFF,5'b00101,8'd7},  // R7
    {1'b1,2'd3,1'b0,64'hC7F0000000000000,64'hFF7FFFFF,5'b00101,8'd7},  // R7
    {1'b1,2'd0,1'b0,64'h47EFFFFFF0000000,64'h7F800000,5'b00101,8'd11}, // R11
    {1'b1,2'd3,1'b0,64'h47EFFFFFF0000000,64'h7F7FFFFF,5'b00001,8'd11}, // R11
    {1'b1,2'd0,1'b0,64'h36A0000000000000,64'h00000001,5'b00000,8'd8},  // R8
    {1'b1,2'd0,1'b0,64'h3690000000000000,64'h00000000,5'b00011,8'd8},  // R8
    {1'b1,2'd2,1'b0,64'h3690000000000000,64'h00000001,5'b00011,8'd8},  // R8
    {1'b1,2'd0,1'b0,64'h36A8000000000000,64'h00000002,5'b00011,8'd8},  // R8
    {1'b1,2'd0,1'b0,64'h3800000000000000,64'h00400000,5'b00000,8'd8},  // R8
    {1'b1,2'd0,1'b0,64'h380FFFFFE0000000,64'h00800000,5'b00011,8'd11}, // R11
    {1'b1,2'd0,1'b0,64'h380FFFFFF0000000,64'h00800000,5'b00001,8'd8},  // R8
    {1'b1,2'd0,1'b0,64'h0000000000000001,64'h00000000,5'b01011,8'd9},  // R9
    {1'b1,2'd2,1'b0,64'h0000000000000001,64'h00000001,5'b01011,8'd9},  // R9
    {1'b1,2'd1,1'b0,64'h8000000000000001,64'h80000001,5'b01011,8'd9},  // R9
    {1'b1,2'd0,1'b1,64'h8000000000000001,64'h80000000,5'b00000,8'd9},  // R9
    {1'b1,2'd0,1'b0,64'hFFF0000000000000,64'hFF800000,5'b00000,8'd10}, // R10
    {1'b1,2'd0,1'b0,64'h8000000000000000,64'h80000000,5'b00000,8'd10}  // R10
  };

  function automatic logic [4:0] flags_now();
    return {exc_invalid, exc_denorm, exc_overflow, exc_underflow, exc_inexact};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input logic [4:0] af, input logic [4:0] ef, input logic av, input logic ev);
    n_tests++;
    if (act !== exp || af !== ef || av !== ev) begin
      n_fail++;
      $display("FAIL %s: result %h flags %b valid %b, expected %h flags %b valid %b",
               req, act, af, av, exp, ef, ev);
    end
  endtask

  task automatic apply(input logic n, input logic [1:0] rm, input logic dz, input logic [63:0] op);
    @(negedge clk);
    narrow   = n;
    rmode    = rm;
    daz      = dz;
    opnd     = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    narrow   = 1'b0;
    opnd     = '0;
    rmode    = 2'd0;
    daz      = 1'b0;
    repeat (3) @(negedge clk);
    // R12: held in reset
    check("R12", result, 64'h0, flags_now(), 5'b0, out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12: after release, before any valid operand
    check("R12", result, 64'h0, flags_now(), 5'b0, out_valid, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [144:0] e;
      string tag;
      e = VEC[i];
      apply(e[144], e[143:142], e[141], e[140:77]);
      tag = $sformatf("R%0d vec%0d", e[7:0], i);
      check(tag, result, e[76:13], flags_now(), e[12:8], out_valid, 1'b1);
    end

    // R1: idle cycles hold result and flags while operand changes
    apply(1'b1, 2'd0, 1'b0, 64'h47F0000000000000);
    opnd   = 64'h0000000000000001;
    narrow = 1'b0;
    @(negedge clk);
    check("R1 hold", result, 64'h7F800000, flags_now(), 5'b00101, out_valid, 1'b0);
    opnd = 64'hFF800001;
    @(negedge clk);
    check("R1 hold", result, 64'h7F800000, flags_now(), 5'b00101, out_valid, 1'b0);

    // R1: back-to-back operands each due one edge later
    @(negedge clk);
    narrow = 1'b1; rmode = 2'd0; daz = 1'b0; opnd = 64'h3FF0000000000000; in_valid = 1'b1;
    @(negedge clk);
    check("R1 stream", result, 64'h3F800000, flags_now(), 5'b0, out_valid, 1'b1);
    narrow = 1'b0; opnd = 64'hFF800001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream", result, 64'hFFF8000020000000, flags_now(), 5'b10000, out_valid, 1'b1);

    // R12: asynchronous reset mid-run clears everything
    apply(1'b1, 2'd0, 1'b0, 64'h0000000000000001);
    #1 rst_n = 1'b0;
    #1;
    check("R12 async", result, 64'h0, flags_now(), 5'b0, out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 release", result, 64'h0, flags_now(), 5'b0, out_valid, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule